// File: doc/BRIEF.md
# Flow-through burst SRAM with back-to-back read/write commands

This block is a synchronous single-port word memory driven by a command interface with no bus turnaround penalty. It registers one command at every clock edge that its active-low clock enable qualifies. The command is a fresh read, a fresh write, a deselect or a burst step. Read data flows straight from the array to the output during the cycle after the address edge. Write data and its byte-lane selects arrive one enabled edge after their address. Reads and writes can therefore alternate freely on the shared bus without idle cycles.

A two-bit burst sequencer produces up to four accesses from one loaded address. It uses either linear or interleaved order and touches only the two lowest address bits. The bidirectional data bus is split into an input, an output and an output-valid flag. The flag is gated asynchronously by an active-low output enable. Three chip-select inputs qualify a load. Word width is the product of the byte count and the byte width. The depth is set by the address width.

Top module: `fts_sram`

## Requirements
- R1: An edge with `stall_n_en` high changes nothing. The access state, the burst position and the type are held. A pending write is not committed, and the output keeps showing the same word.
- R2: A load occurs at an edge with `stall_n_en` low, `adv_step` low, `sel_a_n` low, `sel_b` high and `sel_c_n` low. The address is registered at that edge. `we_n` high at that edge starts a read, and `we_n` low starts a write.
- R3: During a read cycle, `dout` carries the array word at the current access address without waiting for another edge. `dout_vld` is 1 exactly while a read is active and `oe_n` is low, and it follows `oe_n` without a clock.
- R4: When a deselect is registered (`adv_step` low with any select inactive), `dout_vld` is 0 from that edge onwards until a new read is loaded.
- R5: During a write cycle `dout_vld` is 0 whatever `oe_n` is. `din` and `byte_we_n` are sampled at the next enabled edge, which completes the write, and the command presented at that same edge is accepted normally.
- R6: Byte lane i is bits [8i+7:8i] of the word. It is written only when `byte_we_n[i]` is 0. Lanes whose select is 1 keep their previous contents.
- R7: At an enabled edge with `adv_step` high, the burst position advances whatever the selects and `we_n` are. The access keeps the read or write type set at its load.
- R8: With start offset s in the low two address bits and beat n (0 to 3), `burst_ord` = 0 gives low bits (s+n) mod 4 and `burst_ord` = 1 gives s XOR n. The upper address bits never change during a burst, and the fifth beat wraps back to s.
- R9: After a deselect, burst steps start no access. No output is driven and no word is written until a new load.
- R10: A read loaded at the edge that completes a write to the same word returns the newly written bytes in the very next cycle.
- R11: Reset (`rst_n` low) clears the active-access and pending-write state, so `dout_vld` is 0 and a later step neither reads nor writes. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_n_en | input | 1 | Active-low clock qualifier; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_step | input | 1 | 1 = burst step, 0 = load or deselect |
| we_n | input | 1 | Write enable at load, active low |
| burst_ord | input | 1 | 0 = linear burst, 1 = interleaved burst |
| addr | input | AW | Word address sampled at a load |
| byte_we_n | input | NB | Per-lane write selects, active low, sampled with din |
| din | input | NB*BW | Write data, one enabled edge after the write address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NB*BW | Read data, flow-through from the array |
| dout_vld | output | 1 | High when dout is being driven onto the bus |

## Verification
The hardest situations to reach are those where a command lands on the edge that retires a write. Examples are a read of the same word, a stall that must keep the write pending, and a write burst whose steps carry junk selects and `we_n`. The stimulus chains writes so that every load of the fill sweep also completes the previous write. It follows each lane-mask write directly with a read of that word. It inserts stalls between a write address and its data, and also in the middle of read bursts. Bursts are swept over both orders and all four start offsets, with a fifth beat that wraps.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_DESEL = 2'd2,
    OP_STEP  = 2'd3
  } op_e;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/fts_cmd_dec.sv
module fts_cmd_dec
  import fts_pkg::*;
(
  input  logic stall_n_en,
  input  logic sel_a_n,
  input  logic sel_b,
  input  logic sel_c_n,
  input  logic adv_step,
  output op_e  op
);
  logic all_sel;

  assign all_sel = ~sel_a_n & sel_b & ~sel_c_n;

  always_comb begin
    if (stall_n_en)    op = OP_HOLD;
    else if (adv_step) op = OP_STEP;
    else if (all_sel)  op = OP_LOAD;
    else               op = OP_DESEL;
  end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
  import fts_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] addr_in,
  input  logic          order,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:2] up_q, up_d;
  logic [1:0]    start_q, start_d;
  logic [1:0]    beat_q, beat_d;
  logic [1:0]    low;

  always_comb begin
    up_d    = up_q;
    start_d = start_q;
    beat_d  = beat_q;
    case (op)
      OP_LOAD: begin
        up_d    = addr_in[AW-1:2];
        start_d = addr_in[1:0];
        beat_d  = 2'd0;
      end
      OP_STEP: beat_d = beat_q + 2'd1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= '0;
      start_q <= 2'd0;
      beat_q  <= 2'd0;
    end else begin
      up_q    <= up_d;
      start_q <= start_d;
      beat_q  <= beat_d;
    end
  end

  always_comb begin
    if (order_e'(order) == ORD_INTERLEAVE) low = start_q ^ beat_q;
    else                                   low = start_q + beat_q;
  end

  assign cur_addr = {up_q, low};

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (beat_q == 2'd0 && cur_addr == $past(addr_in))); // R2
  AST_STALL_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> ($stable(beat_q) && $stable(start_q) && $stable(up_q))); // R1
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> $stable(up_q)); // R8
endmodule

// File: rtl/fts_store.sv
module fts_store #(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [NB-1:0]    wr_lane,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NB*BW-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NB*BW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lane[g]) lane_mem[wr_addr] <= wr_data[g*BW +: BW];
    end

    assign rd_data[g*BW +: BW] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_n_en,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             adv_step,
  input  logic             we_n,
  input  logic             burst_ord,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    byte_we_n,
  input  logic [NB*BW-1:0] din,
  input  logic             oe_n,
  output logic [NB*BW-1:0] dout,
  output logic             dout_vld
);
  localparam int unsigned DW = NB * BW;

  op_e           op;
  logic          act_q, act_d;
  logic          wr_q, wr_d;
  logic          wr_fire;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rd_data;

  fts_cmd_dec u_dec (
    .stall_n_en (stall_n_en),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .adv_step   (adv_step),
    .op         (op)
  );

  fts_burst_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .addr_in  (addr),
    .order    (burst_ord),
    .cur_addr (cur_addr)
  );

  always_comb begin
    act_d = act_q;
    wr_d  = wr_q;
    case (op)
      OP_LOAD: begin
        act_d = 1'b1;
        wr_d  = ~we_n;
      end
      OP_DESEL: begin
        act_d = 1'b0;
        wr_d  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      wr_q  <= wr_d;
    end
  end

  assign wr_fire = (op != OP_HOLD) && act_q && wr_q;

  fts_store #(.AW(AW), .NB(NB), .BW(BW)) u_store (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_lane (~byte_we_n),
    .wr_addr (cur_addr),
    .wr_data (din),
    .rd_addr (cur_addr),
    .rd_data (rd_data)
  );

  assign dout     = rd_data;
  assign dout_vld = act_q & ~wr_q & ~oe_n;

  AST_STALL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> ($stable(act_q) && $stable(wr_q))); // R1
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> !dout_vld); // R4
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD && !we_n) |=> !dout_vld); // R5
  AST_STEP_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> $stable(wr_q)); // R7
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && !act_q) |=> (!act_q && !dout_vld)); // R9
endmodule

// File: tb/fts_sram_test.sv
module fts_sram_test;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall_n_en = 1'b0;
  logic          sel_a_n = 1'b1;
  logic          sel_b = 1'b0;
  logic          sel_c_n = 1'b1;
  logic          adv_step = 1'b0;
  logic          we_n = 1'b1;
  logic          burst_ord = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byte_we_n = '0;
  logic [DW-1:0] din = '0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_vld;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] sh [DEPTH];
  bit m_act = 1'b0;
  bit m_wr = 1'b0;
  int m_up = 0;
  int m_start = 0;
  int m_beat = 0;

  always #10 clk = ~clk;

  fts_sram #(.AW(AW), .NB(NB), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .stall_n_en(stall_n_en), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .adv_step(adv_step), .we_n(we_n),
    .burst_ord(burst_ord), .addr(addr), .byte_we_n(byte_we_n), .din(din),
    .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic int cur_word();
    int low;
    if (burst_ord) low = m_start ^ m_beat;
    else           low = (m_start + m_beat) % 4;
    return m_up * 4 + low;
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA55A_0000 ^ (a * 32'h0103_0507);
  endfunction

  task automatic model_edge();
    if (!stall_n_en) begin
      if (m_act && m_wr) begin
        for (int l = 0; l < NB; l++)
          if (!byte_we_n[l]) sh[cur_word()][l*BW +: BW] = din[l*BW +: BW];
      end
      if (adv_step) m_beat = (m_beat + 1) % 4;
      else if (!sel_a_n && sel_b && !sel_c_n) begin
        m_act = 1'b1; m_wr = !we_n;
        m_up = int'(addr) / 4; m_start = int'(addr) % 4; m_beat = 0;
      end else begin
        m_act = 1'b0; m_wr = 1'b0;
      end
    end
  endtask

  task automatic check(input string tag);
    bit exp_en;
    exp_en = m_act && !m_wr && !oe_n;
    vectors++;
    if (dout_vld !== exp_en) begin
      fails++;
      $display("FAIL %s: dout_vld=%0b expected %0b", tag, dout_vld, exp_en);
    end else if (exp_en && dout !== sh[cur_word()]) begin
      fails++;
      $display("FAIL %s: dout=%h expected %h (word %0d)", tag, dout, sh[cur_word()], cur_word());
    end
  endtask

  task automatic edge_go(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    check(tag);
  endtask

  task automatic do_load(input int a, input bit wr, input string tag);
    stall_n_en = 1'b0; adv_step = 1'b0;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    we_n = !wr; addr = AW'(a);
    edge_go(tag);
  endtask

  task automatic do_desel(input string tag);
    stall_n_en = 1'b0; adv_step = 1'b0;
    sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
    edge_go(tag);
  endtask

  task automatic do_step(input string tag);
    stall_n_en = 1'b0; adv_step = 1'b1;
    sel_a_n = vectors[0]; sel_b = vectors[1]; sel_c_n = vectors[2];
    we_n = vectors[3]; addr = AW'(vectors * 7);
    edge_go(tag);
  endtask

  task automatic do_stall(input string tag);
    stall_n_en = 1'b1; adv_step = vectors[0];
    sel_a_n = vectors[1]; sel_b = 1'b1; sel_c_n = 1'b0;
    we_n = vectors[2]; addr = AW'(vectors * 5);
    din = ~din; byte_we_n = ~byte_we_n;
    edge_go(tag);
    byte_we_n = ~byte_we_n;
    stall_n_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R11 reset");
    rst_n = 1'b1;
    do_step("R11 step after reset");
    do_step("R11 step after reset");

    // R2 R5: chained fill, each load completes the previous write
    byte_we_n = '0;
    for (int a = 0; a < DEPTH; a++) begin
      if (a > 0) din = pat(a - 1);
      do_load(a, 1'b1, "R2 fill");
    end
    din = pat(DEPTH - 1);
    oe_n = 1'b0;
    do_desel("R4 deselect");

    // R3: single reads and asynchronous output enable
    for (int a = 0; a < DEPTH; a++) begin
      do_load(a, 1'b0, "R3 read");
      oe_n = 1'b1; #1; check("R3 oe high");
      oe_n = 1'b0; #1; check("R3 oe low");
    end

    // R5 R10: write then immediate read of the same word
    for (int a = 0; a < 16; a++) begin
      oe_n = a[0];
      do_load(a, 1'b1, "R5 write cycle");
      oe_n = 1'b0;
      din = ~pat(a) + DW'(a);
      do_load(a, 1'b0, "R10 read after write");
    end

    // R8: both orders, all start offsets, fifth beat wraps
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 4; s++) begin
        burst_ord = md[0];
        do_load(4 * (8 + s + 4 * md) + s, 1'b0, "R8 burst load");
        for (int n = 0; n < 5; n++) do_step("R8 burst beat");
      end

    // R7: write bursts with junk selects on the steps, then read back
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 4; s++) begin
        burst_ord = md[0];
        do_load(4 * (4 + s) + s, 1'b1, "R7 write burst");
        for (int n = 0; n < 3; n++) begin
          din = pat(100 + 8 * md + 2 * s + n);
          do_step("R7 write beat");
        end
        din = 32'h5A5A_0000 + DW'(s + 4 * md);
        do_desel("R7 end burst");
        do_load(4 * (4 + s) + s, 1'b0, "R7 read burst");
        for (int n = 0; n < 4; n++) do_step("R7 read beat");
      end
    burst_ord = 1'b0;

    // R6: every lane mask
    for (int m = 0; m < 16; m++) begin
      do_load(40, 1'b1, "R6 lane write");
      byte_we_n = ~NB'(m);
      din = 32'h1111_1111 * DW'(m + 1);
      do_load(40, 1'b0, "R6 lane read");
      byte_we_n = '0;
    end

    // R1: stalls hold a pending write and a burst position
    do_load(50, 1'b1, "R1 write load");
    din = 32'hDEAD_BEEF;
    for (int k = 0; k < 3; k++) do_stall("R1 stall write");
    din = 32'hC0FF_EE00;
    do_load(50, 1'b0, "R1 read after stalled write");
    do_load(52, 1'b0, "R1 burst load");
    do_step("R1 burst beat");
    for (int k = 0; k < 3; k++) do_stall("R1 stall burst");
    do_step("R1 burst beat");
    do_step("R1 burst beat");

    // R4 R9: deselect, then steps must neither drive nor write
    do_load(60, 1'b1, "R9 write load");
    din = 32'h0BAD_F00D;
    do_desel("R4 deselect");
    byte_we_n = '0;
    for (int k = 0; k < 4; k++) begin
      din = 32'hFFFF_0000 + DW'(k);
      do_step("R9 step while deselected");
    end
    do_load(60, 1'b0, "R9 read unchanged");
    do_step("R9 read beat");
    do_desel("R4 deselect");
    do_desel("R4 deselect again");

    // R11: reset mid-write, step must not commit
    do_load(61, 1'b1, "R11 write load");
    rst_n = 1'b0;
    m_act = 1'b0; m_wr = 1'b0; m_up = 0; m_start = 0; m_beat = 0;
    #2; check("R11 reset asserted");
    @(posedge clk); #2;
    rst_n = 1'b1;
    din = 32'h1234_5678;
    do_step("R11 step after reset");
    do_load(61, 1'b0, "R11 memory kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule